// File: doc/BRIEF.md
# Multicycle 16-bit Accumulator Processor

A small stored-program processor that keeps one 16-bit accumulator and a byte-addressed program counter. It fetches 16-bit instruction words from an external memory and executes eight operations: bitwise complement, logical shift right, AND with a constant, addition of a constant, load, store, unconditional jump and branch-on-negative. Every instruction takes between two and four clock cycles. A hardwired control state machine drives a datapath built from the program counter, an address-out register, an instruction/data-in register, the accumulator and a small ALU.

The address-out register, not the program counter, drives the memory address. When the machine enters the fetch state, the address-out register already holds the address of the instruction being fetched and the program counter already points at the next word. Every execute path ends by copying the program counter into the address-out register and stepping the program counter by two. Memory is read combinationally: read data must be valid in the same cycle in which the address and the read code are driven. A write takes effect at the clock edge that closes the write cycle.

Top module: `accp_core`

## Requirements
- R1: An instruction word holds the indirect flag in bit 15, a 5-bit opcode in bits 14:10 and a 10-bit operand X in bits 9:0. X is zero-extended to 16 bits wherever it is used as an ALU operand or as an address.
- R2: While reset is held, and for the first two cycles after reset is released, the memory operation is NOP. In the third cycle the first instruction fetch reads address 0.
- R3: The memory operation uses NOP = 00, read = 01 and write = 10. The value 11 never appears.
- R4: Opcode 00110 sets AC = AC AND X, and opcode 00111 sets AC = AC + X modulo 2^16. Opcode 00000 sets AC = NOT AC, and opcode 00001 shifts AC right by one bit with a zero entering bit 15. Each of these instructions takes two cycles, and the next fetch reads the instruction address + 2.
- R5: Store (00100) takes three cycles. In its third cycle it writes AC to address X with the write code. The next cycle is a fetch at the instruction address + 2, and AC is unchanged by the write.
- R6: Load (00101) takes four cycles. In its third cycle it reads address X, and afterwards AC equals the word read from that address. Memory is not written.
- R7: Branch-if-negative (00010) takes three cycles when AC bit 15 is 1, and the next fetch then reads X. When AC bit 15 is 0 it takes two cycles, and the next fetch reads the instruction address + 2.
- R8: Jump (00011) takes two cycles, and the next fetch reads address X.
- R9: The indirect flag has no effect: every instruction behaves as if bit 15 were 0.
- R10: An opcode whose bits 14:13 are not both zero is a two-cycle no-operation. It changes neither AC nor memory, and the next fetch reads the instruction address + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 16 | Byte address to memory (address-out register) |
| memWrData | output | 16 | Write data (the accumulator) |
| memRdData | input | 16 | Read data, valid in the same cycle as the address |
| memOp | output | 2 | Memory operation: 00 NOP, 01 read, 10 write |

## Verification
Two conditions are hard to reach from the ports. The first is the exact cycle placement of the bus activity: the gap between fetches, the execute cycle that carries the operand access, and the address of the fetch that follows. The bench drives a short jump/load/store loop and compares the bus code and address in every cycle from reset release onward. The second is a branch that must be taken. Because the accumulator can only be reached through instructions, the program first builds a negative value with AND 0 and complement. It then places a store on the fall-through path and another store at the not-taken target of a later branch on a positive value, so that a wrong decision leaves a visible mark in memory. For R9 and R10, operands are chosen so that an indirect or a misdecoded interpretation would produce a different stored value.

// File: rtl/accp_pkg.sv
package accp_pkg;

  localparam int DATA_W = 16;
  localparam int OPC_W  = 5;

  typedef enum logic [1:0] {
    MEM_NOP = 2'b00,
    MEM_RD  = 2'b01,
    MEM_WR  = 2'b10
  } mem_op_e;

  typedef enum logic [1:0] {
    PC_HOLD,
    PC_CLR,
    PC_INC,
    PC_XINC
  } pc_sel_e;

  typedef enum logic [1:0] {
    AO_HOLD,
    AO_PC,
    AO_X
  } ao_sel_e;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_NOT,
    ALU_AND,
    ALU_ADD,
    ALU_SHR
  } alu_op_e;

  typedef enum logic [3:0] {
    S_RST1,
    S_RST2,
    S_FETCH,
    S_AOPR,
    S_SOPR,
    S_ST1,
    S_ST2,
    S_LD1,
    S_LD2,
    S_LD3,
    S_BRN1,
    S_BRN2,
    S_JMP,
    S_SKIP
  } cpu_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    pc_sel_e pcSel;
    ao_sel_e aoSel;
    logic    diLd;
    logic    acLd;
    alu_op_e aluOp;
    mem_op_e memOp;
  } strobe_t;

endpackage

// File: rtl/accp_alu.sv
module accp_alu
  import accp_pkg::*;
#(
  parameter int DATA_W = accp_pkg::DATA_W
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    case (op)
      ALU_PASS: res = opA;
      ALU_NOT:  res = ~acc;
      ALU_AND:  res = acc & opA;
      ALU_ADD:  res = acc + opA;
      ALU_SHR:  res = {1'b0, acc[DATA_W-1:1]};
      default:  res = opA;
    endcase
  end

endmodule

// File: rtl/accp_dpath.sv
module accp_dpath
  import accp_pkg::*;
#(
  parameter int DATA_W = accp_pkg::DATA_W,
  parameter int OPC_W  = accp_pkg::OPC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           cs,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [OPC_W-1:0]  irOpc,
  output logic              acNeg,
  output logic [DATA_W-1:0] pcVal,
  output logic [DATA_W-1:0] accVal
);

  localparam int X_W = DATA_W - OPC_W - 1;
  localparam logic [DATA_W-1:0] PC_STEP = DATA_W[DATA_W-1:0] >> 3;

  logic [DATA_W-1:0] pcQ, aoQ, diQ, accQ;
  logic [DATA_W-1:0] xExt, aluA, aluRes;
  logic              unusedIndirect;

  assign xExt = {{(DATA_W - X_W){1'b0}}, diQ[X_W-1:0]};
  assign aluA = (cs.aluOp == ALU_PASS) ? diQ : xExt;
  assign unusedIndirect = diQ[DATA_W-1];

  accp_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (cs.aluOp),
    .opA (aluA),
    .acc (accQ),
    .res (aluRes)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= '0;
      aoQ  <= '0;
      diQ  <= '0;
      accQ <= '0;
    end else begin
      case (cs.pcSel)
        PC_CLR:  pcQ <= '0;
        PC_INC:  pcQ <= pcQ + PC_STEP;
        PC_XINC: pcQ <= xExt + PC_STEP;
        default: pcQ <= pcQ;
      endcase
      case (cs.aoSel)
        AO_PC:   aoQ <= pcQ;
        AO_X:    aoQ <= xExt;
        default: aoQ <= aoQ;
      endcase
      if (cs.diLd) diQ <= memRdData;
      if (cs.acLd) accQ <= aluRes;
    end
  end

  assign memAddr   = aoQ;
  assign memWrData = accQ;
  assign irOpc     = diQ[DATA_W-2 -: OPC_W];
  assign acNeg     = accQ[DATA_W-1];
  assign pcVal     = pcQ;
  assign accVal    = accQ;

endmodule

// File: rtl/accp_ctrl.sv
module accp_ctrl
  import accp_pkg::*;
#(
  parameter int OPC_W = accp_pkg::OPC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] fetchOpc,
  input  logic [OPC_W-1:0] irOpc,
  input  logic             acNeg,
  output strobe_t          cs
);

  cpu_state_e stateQ, stateD;
  logic       unusedIrBits;

  assign unusedIrBits = ^irOpc[OPC_W-1:1];

  function automatic cpu_state_e firstExec(input logic [OPC_W-1:0] opc);
    if (opc[OPC_W-1:3] != '0) return S_SKIP;
    case (opc[2:0])
      3'b000, 3'b001: return S_SOPR;
      3'b010:         return S_BRN1;
      3'b011:         return S_JMP;
      3'b100:         return S_ST1;
      3'b101:         return S_LD1;
      default:        return S_AOPR;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_RST1;
    else       stateQ <= stateD;
  end

  always_comb begin
    cs       = '{pcSel: PC_HOLD, aoSel: AO_HOLD, diLd: 1'b0, acLd: 1'b0,
                 aluOp: ALU_PASS, memOp: MEM_NOP};
    stateD   = stateQ;
    case (stateQ)
      S_RST1: begin
        cs.pcSel = PC_CLR;
        stateD   = S_RST2;
      end
      S_RST2: begin
        cs.aoSel = AO_PC;
        cs.pcSel = PC_INC;
        stateD   = S_FETCH;
      end
      S_FETCH: begin
        cs.memOp = MEM_RD;
        cs.diLd  = 1'b1;
        stateD   = firstExec(fetchOpc);
      end
      S_AOPR: begin
        cs.aluOp = irOpc[0] ? ALU_ADD : ALU_AND;
        cs.acLd  = 1'b1;
        cs.aoSel = AO_PC;
        cs.pcSel = PC_INC;
        stateD   = S_FETCH;
      end
      S_SOPR: begin
        cs.aluOp = irOpc[0] ? ALU_SHR : ALU_NOT;
        cs.acLd  = 1'b1;
        cs.aoSel = AO_PC;
        cs.pcSel = PC_INC;
        stateD   = S_FETCH;
      end
      S_ST1: begin
        cs.aoSel = AO_X;
        stateD   = S_ST2;
      end
      S_ST2: begin
        cs.memOp = MEM_WR;
        cs.aoSel = AO_PC;
        cs.pcSel = PC_INC;
        stateD   = S_FETCH;
      end
      S_LD1: begin
        cs.aoSel = AO_X;
        stateD   = S_LD2;
      end
      S_LD2: begin
        cs.memOp = MEM_RD;
        cs.diLd  = 1'b1;
        stateD   = S_LD3;
      end
      S_LD3: begin
        cs.aluOp = ALU_PASS;
        cs.acLd  = 1'b1;
        cs.aoSel = AO_PC;
        cs.pcSel = PC_INC;
        stateD   = S_FETCH;
      end
      S_BRN1: begin
        cs.aoSel = AO_PC;
        cs.pcSel = PC_INC;
        stateD   = acNeg ? S_BRN2 : S_FETCH;
      end
      S_BRN2, S_JMP: begin
        cs.aoSel = AO_X;
        cs.pcSel = PC_XINC;
        stateD   = S_FETCH;
      end
      S_SKIP: begin
        cs.aoSel = AO_PC;
        cs.pcSel = PC_INC;
        stateD   = S_FETCH;
      end
      default: stateD = S_RST1;
    endcase
  end

endmodule

// File: rtl/accp_core.sv
module accp_core
  import accp_pkg::*;
#(
  parameter int DATA_W = accp_pkg::DATA_W,
  parameter int OPC_W  = accp_pkg::OPC_W
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [1:0]        memOp
);

  strobe_t           cs;
  logic [OPC_W-1:0]  irOpc;
  logic              acNeg;
  logic [DATA_W-1:0] pcVal, accVal;

  accp_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fetchOpc (memRdData[DATA_W-2 -: OPC_W]),
    .irOpc    (irOpc),
    .acNeg    (acNeg),
    .cs       (cs)
  );

  accp_dpath #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .cs        (cs),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .irOpc     (irOpc),
    .acNeg     (acNeg),
    .pcVal     (pcVal),
    .accVal    (accVal)
  );

  assign memOp = cs.memOp;

endmodule

// File: rtl/accp_chk.sv
module accp_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        memOp,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] pcVal,
  input logic [DATA_W-1:0] accVal
);

  AST_NO_RESERVED_OP: assert property (@(posedge clk) disable iff (!rstN)
    memOp != 2'b11);                                                  // R3

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> memOp == 2'b00);                                  // R2

  AST_WRITE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    memOp == 2'b10 |=> memOp == 2'b01 && memAddr == $past(pcVal));    // R5

  AST_ACC_STABLE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memOp == 2'b10 |=> $stable(accVal));                              // R5

endmodule

bind accp_core accp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memOp   (memOp),
  .memAddr (memAddr),
  .pcVal   (pcVal),
  .accVal  (accVal)
);

// File: tb/accp_core_tb.sv
module accp_core_tb;

  localparam logic [4:0] OP_COMP = 5'b00000;
  localparam logic [4:0] OP_SHR  = 5'b00001;
  localparam logic [4:0] OP_BRN  = 5'b00010;
  localparam logic [4:0] OP_JMP  = 5'b00011;
  localparam logic [4:0] OP_ST   = 5'b00100;
  localparam logic [4:0] OP_LD   = 5'b00101;
  localparam logic [4:0] OP_AND  = 5'b00110;
  localparam logic [4:0] OP_ADD  = 5'b00111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memAddr, memWrData, memRdData;
  logic [1:0]  memOp;
  logic [15:0] mem [0:511];
  int          nChecks = 0;
  int          nFail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  accp_core u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memRdData (memRdData),
    .memOp     (memOp)
  );

  assign memRdData = mem[memAddr[9:1]];

  always @(posedge clk)
    if (memOp == 2'b10) mem[memAddr[9:1]] <= memWrData;

  function automatic logic [15:0] enc(input logic [4:0] opc, input logic [9:0] x,
                                      input logic ind = 1'b0);
    return {ind, opc, x};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("[TB] FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int byteAddr, input logic [15:0] w);
    mem[byteAddr >> 1] <= w;
  endtask

  task automatic startReset();
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 512; i++) mem[i] <= 16'h0000;
    @(negedge clk);
    check("R2 op during reset", {14'd0, memOp}, 16'h0000);
  endtask

  task automatic releaseReset();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busCheck(input string tag, input logic [1:0] op, input logic [15:0] addr);
    check({tag, " op"}, {14'd0, memOp}, {14'd0, op});
    if (op != 2'b00) check({tag, " addr"}, memAddr, addr);
    @(negedge clk);
  endtask

  // R2 R3 R5 R6 R8: cycle placement on the bus
  task automatic testTrace();
    startReset();
    put(16'h000, enc(OP_JMP, 10'h040));
    put(16'h040, enc(OP_LD,  10'h200));
    put(16'h042, enc(OP_ST,  10'h202));
    put(16'h044, enc(OP_JMP, 10'h040));
    put(16'h200, 16'h9ABC);
    releaseReset();
    busCheck("R2 c0", 2'b00, 16'h0);
    busCheck("R2 c1", 2'b00, 16'h0);
    busCheck("R2 first fetch", 2'b01, 16'h0000);
    busCheck("R8 jump exec", 2'b00, 16'h0);
    busCheck("R8 fetch at X", 2'b01, 16'h0040);
    busCheck("R6 ld1", 2'b00, 16'h0);
    busCheck("R6 operand read", 2'b01, 16'h0200);
    busCheck("R6 ld3", 2'b00, 16'h0);
    busCheck("R6 next fetch", 2'b01, 16'h0042);
    busCheck("R5 st1", 2'b00, 16'h0);
    check("R5 write data", memWrData, 16'h9ABC);
    busCheck("R5 write", 2'b10, 16'h0202);
    busCheck("R5 next fetch", 2'b01, 16'h0044);
    busCheck("R8 jump exec2", 2'b00, 16'h0);
    busCheck("R8 loop fetch", 2'b01, 16'h0040);
    check("R5 stored word", mem[16'h202 >> 1], 16'h9ABC);
  endtask

  // R4: ALU operations
  task automatic testArith();
    startReset();
    put(16'h000, enc(OP_AND,  10'h000));
    put(16'h002, enc(OP_ADD,  10'h3FF));
    put(16'h004, enc(OP_ST,   10'h100));
    put(16'h006, enc(OP_COMP, 10'h000));
    put(16'h008, enc(OP_ST,   10'h102));
    put(16'h00A, enc(OP_SHR,  10'h000));
    put(16'h00C, enc(OP_ST,   10'h104));
    put(16'h00E, enc(OP_JMP,  10'h00E));
    releaseReset();
    runCycles(60);
    check("R4 add zext X", mem[16'h100 >> 1], 16'h03FF);
    check("R4 complement", mem[16'h102 >> 1], 16'hFC00);
    check("R4 logical shr", mem[16'h104 >> 1], 16'h7E00);
  endtask

  // R6 R4: load, add wrap, and
  task automatic testLoad();
    startReset();
    put(16'h000, enc(OP_LD,  10'h200));
    put(16'h002, enc(OP_ADD, 10'h005));
    put(16'h004, enc(OP_ST,  10'h202));
    put(16'h006, enc(OP_AND, 10'h0F0));
    put(16'h008, enc(OP_ST,  10'h208));
    put(16'h00A, enc(OP_LD,  10'h204));
    put(16'h00C, enc(OP_ADD, 10'h002));
    put(16'h00E, enc(OP_ST,  10'h20A));
    put(16'h010, enc(OP_JMP, 10'h010));
    put(16'h200, 16'h1234);
    put(16'h204, 16'hFFFF);
    releaseReset();
    runCycles(80);
    check("R6 load then add", mem[16'h202 >> 1], 16'h1239);
    check("R4 and", mem[16'h208 >> 1], 16'h0030);
    check("R4 add wraps", mem[16'h20A >> 1], 16'h0001);
    check("R6 source untouched", mem[16'h200 >> 1], 16'h1234);
  endtask

  // R7: branch taken and not taken
  task automatic testBranch();
    startReset();
    put(16'h000, enc(OP_AND,  10'h000));
    put(16'h002, enc(OP_COMP, 10'h000));
    put(16'h004, enc(OP_BRN,  10'h020));
    put(16'h006, enc(OP_ST,   10'h300));
    put(16'h008, enc(OP_JMP,  10'h008));
    put(16'h020, enc(OP_AND,  10'h000));
    put(16'h022, enc(OP_ADD,  10'h007));
    put(16'h024, enc(OP_BRN,  10'h040));
    put(16'h026, enc(OP_ADD,  10'h001));
    put(16'h028, enc(OP_ST,   10'h302));
    put(16'h02A, enc(OP_JMP,  10'h02A));
    put(16'h040, enc(OP_ST,   10'h304));
    put(16'h042, enc(OP_JMP,  10'h042));
    put(16'h300, 16'hDEAD);
    put(16'h304, 16'hBEEF);
    releaseReset();
    runCycles(80);
    check("R7 taken skips store", mem[16'h300 >> 1], 16'hDEAD);
    check("R7 not taken falls through", mem[16'h302 >> 1], 16'h0008);
    check("R7 not-taken target unused", mem[16'h304 >> 1], 16'hBEEF);
  endtask

  // R1 R9 R10: indirect flag and undefined opcodes
  task automatic testIgnored();
    startReset();
    put(16'h000, enc(OP_AND,   10'h000, 1'b1));
    put(16'h002, enc(OP_ADD,   10'h123, 1'b1));
    put(16'h004, enc(5'b10111, 10'h3FF));
    put(16'h006, enc(5'b01100, 10'h310));
    put(16'h008, enc(OP_ST,    10'h312, 1'b1));
    put(16'h00A, enc(OP_JMP,   10'h00A, 1'b1));
    put(16'h122, 16'h5555);
    put(16'h310, 16'hA5A5);
    releaseReset();
    runCycles(60);
    check("R9 R1 indirect flag ignored", mem[16'h312 >> 1], 16'h0123);
    check("R10 undefined opcode no store", mem[16'h310 >> 1], 16'hA5A5);
    check("R9 no indirect target write", mem[16'h122 >> 1], 16'h5555);
  endtask

  initial begin
    testTrace();
    testArith();
    testLoad();
    testBranch();
    testIgnored();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("[TB] FAIL watchdog R2 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule